// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block holds the digital side of a dual-slope integrating converter. It steps through three phases in a fixed order: signal integrate, reference de-integrate and auto-zero. For each phase it drives one switch enable for the external integrator network. During de-integrate it counts clocks until the external comparator reports that the integrator has returned through zero. The final count is then stored as a 4½-digit BCD reading, together with a sign bit and an overrange flag.

The comparator output enters through a single sampling register, read once per clock. That register makes the crossing reach the counter one clock late. The sequencer cancels this by holding the counter off for the first de-integrate clock, so no correction is needed in the result. A second, programmable correction covers the fixed count that slow analog settling adds at a given clock rate. That many counts are skipped before the digit counter starts, which subtracts the offset from the reading and saturates it at zero.

The integrate phase has a fixed length. One conversion always takes the same total number of clocks, whatever the reading, because auto-zero absorbs the time that de-integrate leaves unused.

Top module: `dsadc_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to auto-zero. Only `azEn` is high, all counters clear, and `digitsOut`, `msdOut`, `polOut`, `ovfOut` and `validOut` are 0. After reset is released, the first auto-zero lasts `CYCLE_CLKS` clocks.
- R2: Exactly one of `azEn`, `intEn`, `refPosEn`, `refNegEn` is high in every clock. The phase order is integrate, then de-integrate, then auto-zero, then integrate again. From the start of one integrate to the start of the next is always `CYCLE_CLKS` clocks.
- R3: `cmpIn` is sampled only at rising clock edges. A pulse on `cmpIn` that starts and ends between two rising edges has no effect on the reading.
- R4: Number the de-integrate clocks from 0. If `cmpIn` changes away from its integrate level during clock m and stays changed, de-integrate lasts m+2 clocks, and with a zero offset the latched reading is exactly m.
- R5: With `offsetIn` = c, sampled in the last integrate clock, the reading is m−c when m ≥ c and 0 otherwise.
- R6: The level of `cmpIn` held through integrate sets the sign. With a high level, `polOut` becomes 1 and `refNegEn` is the de-integrate enable. With a low level, `polOut` becomes 0 and `refPosEn` is used.
- R7: If no crossing is seen by de-integrate clock `FULL_SCALE`, de-integrate ends there after `FULL_SCALE`+1 clocks. `ovfOut` then becomes 1, and all digits, including `msdOut`, read 0. The next in-range conversion clears `ovfOut`.
- R8: The reading is BCD. `digitsOut[3:0]` holds the units digit, and each higher 4-bit group holds the next decimal place, up to thousands in `[15:12]`. `msdOut` is the ten-thousands digit, limited to 0 or 1. Every 4-bit group stays in the range 0 to 9.
- R9: `validOut` is high for exactly one clock, the first auto-zero clock after each de-integrate. The new reading, sign and overrange flag appear in that same clock and hold until the next `validOut`.
- R10: Integrate lasts exactly `INT_CLKS` clocks, with no hold-off clock at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmpIn | input | 1 | External comparator output, high when the integrated input is positive |
| offsetIn | input | OFFS_W | Count subtracted from each reading |
| azEn | output | 1 | Auto-zero switch enable |
| intEn | output | 1 | Signal integrate switch enable |
| refPosEn | output | 1 | De-integrate enable with the positive reference |
| refNegEn | output | 1 | De-integrate enable with the negative reference |
| digitsOut | output | 4*NDIG | Latched BCD digits, units in the low nibble |
| msdOut | output | 1 | Latched leading half digit (0 or 1) |
| polOut | output | 1 | Latched sign, 1 for positive input |
| ovfOut | output | 1 | Latched overrange flag |
| validOut | output | 1 | One-clock strobe marking a new reading |

## Verification
The properties assume that `cmpIn` keeps one level through each integrate phase and changes at most once during de-integrate. Only then do the captured sign and the de-integrate enable keep the fixed relation the checks rely on. The properties also assume that `CYCLE_CLKS` leaves room for the longest de-integrate plus at least one auto-zero clock. The stimulus sets the comparator level on the first integrate clock. It flips the level once, on a chosen de-integrate clock, and puts it back only in the next integrate. The one deliberate exception is the glitch case: there the pulse starts and ends between two rising edges, so the sampling register never sees it.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_t;

  // strobes from the sequencer to the counting datapath
  typedef struct packed {
    logic capPol;    // take the sign from the sampled comparator
    logic loadSkip;  // load the offset skip counter
    logic clrCount;  // clear the BCD count
    logic cntEn;     // one de-integrate count slot
    logic latch;     // store the result into the output registers
    logic ovf;       // the stored result is an overrange
  } seqStrobe_t;

endpackage

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int INT_CLKS   = 10000,
  parameter int FULL_SCALE = 20000,
  parameter int CYCLE_CLKS = 40000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       xing,
  input  logic       polIn,
  output seqStrobe_t stb,
  output logic       azEn,
  output logic       intEn,
  output logic       refPosEn,
  output logic       refNegEn
);

  localparam int CNT_W = $clog2(CYCLE_CLKS);
  localparam int DE_W  = $clog2(FULL_SCALE + 1);

  phase_t           phase;
  logic [CNT_W-1:0] cycCnt;
  logic [DE_W-1:0]  deCnt;
  logic             azFirst;

  logic cycLast;
  logic intLast;
  logic deFull;
  logic deDone;

  assign cycLast = (phase == PH_AZ) && (cycCnt == CNT_W'(CYCLE_CLKS - 1));
  assign intLast = (phase == PH_INT) && (cycCnt == CNT_W'(INT_CLKS - 1));
  assign deFull  = (deCnt == DE_W'(FULL_SCALE));
  assign deDone  = (phase == PH_DEINT) && (xing || deFull);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_AZ;
      cycCnt  <= '0;
      deCnt   <= '0;
      azFirst <= 1'b0;
    end else begin
      unique case (phase)
        PH_AZ: begin
          azFirst <= 1'b0;
          if (cycLast) begin
            phase  <= PH_INT;
            cycCnt <= '0;
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        PH_INT: begin
          cycCnt <= cycCnt + 1'b1;
          if (intLast) begin
            phase <= PH_DEINT;
            deCnt <= '0;
          end
        end
        PH_DEINT: begin
          cycCnt <= cycCnt + 1'b1;
          if (deDone) begin
            phase   <= PH_AZ;
            azFirst <= 1'b1;
          end else begin
            deCnt <= deCnt + 1'b1;
          end
        end
        default: begin
          phase  <= PH_AZ;
          cycCnt <= '0;
        end
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.capPol   = intLast;
    stb.loadSkip = intLast;
    // hold-off slots: clear on the way into de-integrate and on the first auto-zero clock
    stb.clrCount = intLast || ((phase == PH_AZ) && azFirst);
    // de-integrate clock 0 never counts: it absorbs the sampling register's lag
    stb.cntEn    = (phase == PH_DEINT) && (deCnt != '0) && !deDone;
    stb.latch    = deDone;
    stb.ovf      = deDone && !xing;
  end

  assign azEn     = (phase == PH_AZ);
  assign intEn    = (phase == PH_INT);
  assign refPosEn = (phase == PH_DEINT) && !polIn;
  assign refNegEn = (phase == PH_DEINT) && polIn;

endmodule

// File: rtl/dsadc_datapath.sv
module dsadc_datapath
  import dsadc_pkg::*;
#(
  parameter int OFFS_W = 8,
  parameter int NDIG   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmpIn,
  input  logic [OFFS_W-1:0] offsetIn,
  input  seqStrobe_t        stb,
  output logic              xing,
  output logic              polReg,
  output logic [4*NDIG-1:0] digitsOut,
  output logic              msdOut,
  output logic              polOut,
  output logic              ovfOut,
  output logic              validOut
);

  localparam int DIG_W = 4 * NDIG;

  logic              cmpReg;
  logic [OFFS_W-1:0] skipCnt;
  logic [3:0]        digit [NDIG];
  logic [NDIG:0]     carry;
  logic              msd;
  logic [DIG_W-1:0]  countVec;

  // comparator sampled once per clock
  always_ff @(posedge clk) begin
    if (rst) begin
      cmpReg <= 1'b0;
      polReg <= 1'b0;
    end else begin
      cmpReg <= cmpIn;
      if (stb.capPol) polReg <= cmpReg;
    end
  end

  assign xing = cmpReg ^ polReg;

  // offset subtraction by skipping the first counts
  always_ff @(posedge clk) begin
    if (rst) begin
      skipCnt <= '0;
    end else if (stb.loadSkip) begin
      skipCnt <= offsetIn;
    end else if (stb.cntEn && (skipCnt != '0)) begin
      skipCnt <= skipCnt - 1'b1;
    end
  end

  assign carry[0] = stb.cntEn && (skipCnt == '0);

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    always_ff @(posedge clk) begin
      if (rst || stb.clrCount) begin
        digit[i] <= 4'd0;
      end else if (carry[i]) begin
        digit[i] <= (digit[i] == 4'd9) ? 4'd0 : digit[i] + 4'd1;
      end
    end
    assign carry[i+1]      = carry[i] && (digit[i] == 4'd9);
    assign countVec[4*i+:4] = digit[i];
  end

  // leading half digit
  always_ff @(posedge clk) begin
    if (rst || stb.clrCount) begin
      msd <= 1'b0;
    end else if (carry[NDIG]) begin
      msd <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      digitsOut <= '0;
      msdOut    <= 1'b0;
      polOut    <= 1'b0;
      ovfOut    <= 1'b0;
      validOut  <= 1'b0;
    end else begin
      validOut <= stb.latch;
      if (stb.latch) begin
        digitsOut <= stb.ovf ? '0 : countVec;
        msdOut    <= stb.ovf ? 1'b0 : msd;
        ovfOut    <= stb.ovf;
        polOut    <= polReg;
      end
    end
  end

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int INT_CLKS   = 10000,
  parameter int FULL_SCALE = 20000,
  parameter int CYCLE_CLKS = 40000,
  parameter int OFFS_W     = 8,
  parameter int NDIG       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmpIn,
  input  logic [OFFS_W-1:0] offsetIn,
  output logic              azEn,
  output logic              intEn,
  output logic              refPosEn,
  output logic              refNegEn,
  output logic [4*NDIG-1:0] digitsOut,
  output logic              msdOut,
  output logic              polOut,
  output logic              ovfOut,
  output logic              validOut
);

  seqStrobe_t stb;
  logic       xing;
  logic       polReg;

  dsadc_ctrl #(
    .INT_CLKS  (INT_CLKS),
    .FULL_SCALE(FULL_SCALE),
    .CYCLE_CLKS(CYCLE_CLKS)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .xing    (xing),
    .polIn   (polReg),
    .stb     (stb),
    .azEn    (azEn),
    .intEn   (intEn),
    .refPosEn(refPosEn),
    .refNegEn(refNegEn)
  );

  dsadc_datapath #(
    .OFFS_W(OFFS_W),
    .NDIG  (NDIG)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .cmpIn    (cmpIn),
    .offsetIn (offsetIn),
    .stb      (stb),
    .xing     (xing),
    .polReg   (polReg),
    .digitsOut(digitsOut),
    .msdOut   (msdOut),
    .polOut   (polOut),
    .ovfOut   (ovfOut),
    .validOut (validOut)
  );

endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int NDIG = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              azEn,
  input logic              intEn,
  input logic              refPosEn,
  input logic              refNegEn,
  input logic [4*NDIG-1:0] digitsOut,
  input logic              msdOut,
  input logic              polOut,
  input logic              ovfOut,
  input logic              validOut
);

  logic deint;
  assign deint = refPosEn || refNegEn;

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $countones({azEn, intEn, refPosEn, refNegEn}) == 1); // R2

  AST_INT_TO_DEINT: assert property (@(posedge clk) disable iff (rst)
    $fell(intEn) |-> deint); // R2

  AST_DEINT_TO_AZ: assert property (@(posedge clk) disable iff (rst)
    ($past(deint) && !deint) |-> azEn); // R2

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    validOut |=> !validOut); // R9

  AST_VALID_AT_AZ: assert property (@(posedge clk) disable iff (rst)
    validOut |-> (azEn && $past(deint))); // R9

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> $stable({digitsOut, msdOut, polOut, ovfOut})); // R9

  AST_OVF_BLANK: assert property (@(posedge clk) disable iff (rst)
    ovfOut |-> ((digitsOut == '0) && !msdOut)); // R7

  AST_SIGN_REF: assert property (@(posedge clk) disable iff (rst)
    validOut |-> (polOut == $past(refNegEn))); // R6

  for (genvar i = 0; i < NDIG; i++) begin : g_rng
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
      digitsOut[4*i+:4] <= 4'd9); // R8
  end

endmodule

bind dsadc_seq dsadc_seq_chk #(.NDIG(NDIG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .azEn     (azEn),
  .intEn    (intEn),
  .refPosEn (refPosEn),
  .refNegEn (refNegEn),
  .digitsOut(digitsOut),
  .msdOut   (msdOut),
  .polOut   (polOut),
  .ovfOut   (ovfOut),
  .validOut (validOut)
);

// File: tb/tb_dsadc_seq.sv
module tb_dsadc_seq;

  localparam int CLK_PERIOD = 10;
  localparam int INT_CLKS   = 100;
  localparam int FULL_SCALE = 10050;
  localparam int CYCLE_CLKS = 10200;
  localparam int OFFS_W     = 8;
  localparam int NDIG       = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic              cmpIn;
  logic [OFFS_W-1:0] offsetIn;
  logic              azEn, intEn, refPosEn, refNegEn;
  logic [4*NDIG-1:0] digitsOut;
  logic              msdOut, polOut, ovfOut, validOut;

  int checks = 0;
  int errors = 0;
  int deLen;
  int validSeen;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsadc_seq #(
    .INT_CLKS(INT_CLKS), .FULL_SCALE(FULL_SCALE), .CYCLE_CLKS(CYCLE_CLKS),
    .OFFS_W(OFFS_W), .NDIG(NDIG)
  ) dut (
    .clk(clk), .rst(rst), .cmpIn(cmpIn), .offsetIn(offsetIn),
    .azEn(azEn), .intEn(intEn), .refPosEn(refPosEn), .refNegEn(refNegEn),
    .digitsOut(digitsOut), .msdOut(msdOut), .polOut(polOut),
    .ovfOut(ovfOut), .validOut(validOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4*NDIG-1:0] lowBcd(input int v);
    logic [4*NDIG-1:0] r;
    int p;
    r = '0;
    p = v;
    for (int i = 0; i < NDIG; i++) begin
      r[4*i+:4] = 4'(p % 10);
      p = p / 10;
    end
    return r;
  endfunction

  // one conversion: sign level lvl, comparator flips on de-integrate clock m
  task automatic convert(input int m, input bit lvl, input int offs,
                         input bit glitch, input bit noCross);
    int k;
    offsetIn = OFFS_W'(offs);
    while (!intEn) @(negedge clk);
    cmpIn = lvl;
    while (intEn) @(negedge clk);
    chk(refNegEn == lvl && refPosEn == !lvl, "R6 reference select",
        int'(refNegEn), int'(lvl));
    k = 0;
    deLen = 0;
    while (refPosEn || refNegEn) begin
      if (!noCross && k == m) cmpIn = !lvl;
      if (glitch && k == 5) begin
        #1 cmpIn = !lvl;
        #2 cmpIn = lvl;
      end
      deLen++;
      k++;
      @(negedge clk);
    end
    validSeen = int'(validOut);
    chk(validOut == 1'b1 && azEn == 1'b1, "R9 strobe in first auto-zero clock",
        int'(validOut), 1);
    @(negedge clk);
    chk(validOut == 1'b0, "R9 strobe one clock wide", int'(validOut), 0);
  endtask

  task automatic expectReading(input string req, input int val, input bit pol);
    chk(digitsOut == lowBcd(val), req, int'(digitsOut), int'(lowBcd(val)));
    chk(msdOut == ((val / 10000) % 10 != 0), {req, " msd"}, int'(msdOut), (val / 10000) % 10);
    chk(polOut == pol, {req, " sign"}, int'(polOut), int'(pol));
    chk(ovfOut == 1'b0, {req, " no overrange"}, int'(ovfOut), 0);
  endtask

  task automatic testReset;
    rst = 1'b1;
    cmpIn = 1'b0;
    offsetIn = '0;
    repeat (3) @(negedge clk);
    chk(azEn && !intEn && !refPosEn && !refNegEn, "R1 auto-zero in reset", int'(azEn), 1);
    chk(digitsOut == '0 && !msdOut && !polOut && !ovfOut && !validOut,
        "R1 outputs cleared", int'(digitsOut), 0);
    rst = 1'b0;
    begin
      int n;
      n = 0;
      while (!intEn) begin
        @(negedge clk);
        n++;
      end
      chk(n == CYCLE_CLKS, "R1 first auto-zero length", n, CYCLE_CLKS);
    end
  endtask

  task automatic testTiming;
    int nInt;
    int period;
    nInt = 0;
    period = 0;
    cmpIn = 1'b1;
    while (intEn) begin
      nInt++;
      period++;
      @(negedge clk);
    end
    while (!intEn) begin
      if (refPosEn || refNegEn) cmpIn = 1'b0;
      period++;
      @(negedge clk);
    end
    chk(nInt == INT_CLKS, "R10 integrate length", nInt, INT_CLKS);
    chk(period == CYCLE_CLKS, "R2 conversion period", period, CYCLE_CLKS);
  endtask

  task automatic testBasic;
    logic [4*NDIG-1:0] held;
    convert(37, 1'b1, 0, 1'b0, 1'b0);
    expectReading("R4 reading 37", 37, 1'b1);
    chk(deLen == 39, "R4 de-integrate length", deLen, 39);
    held = digitsOut;
    repeat (50) @(negedge clk);
    chk(digitsOut == held, "R9 reading held", int'(digitsOut), int'(held));
  endtask

  task automatic testZero;
    convert(0, 1'b1, 0, 1'b0, 1'b0);
    expectReading("R4 reading 0", 0, 1'b1);
    chk(deLen == 2, "R4 shortest de-integrate", deLen, 2);
  endtask

  task automatic testNegative;
    convert(123, 1'b0, 0, 1'b0, 1'b0);
    expectReading("R6 negative reading 123", 123, 1'b0);
  endtask

  task automatic testOffset;
    convert(50, 1'b1, 7, 1'b0, 1'b0);
    expectReading("R5 offset 50-7", 43, 1'b1);
  endtask

  task automatic testOffsetSat;
    convert(3, 1'b1, 9, 1'b0, 1'b0);
    expectReading("R5 offset saturates", 0, 1'b1);
  endtask

  task automatic testGlitch;
    convert(20, 1'b1, 0, 1'b1, 1'b0);
    expectReading("R3 glitch ignored", 20, 1'b1);
  endtask

  task automatic testOverload;
    convert(0, 1'b1, 0, 1'b0, 1'b1);
    chk(ovfOut == 1'b1, "R7 overrange flag", int'(ovfOut), 1);
    chk(digitsOut == '0 && !msdOut, "R7 overrange digits zero", int'(digitsOut), 0);
    chk(deLen == FULL_SCALE + 1, "R7 overrange length", deLen, FULL_SCALE + 1);
  endtask

  task automatic testWide;
    convert(10023, 1'b1, 0, 1'b0, 1'b0);
    expectReading("R8 five-digit reading", 10023, 1'b1);
    chk(ovfOut == 1'b0, "R7 overrange cleared", int'(ovfOut), 0);
  endtask

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    testReset();
    testTiming();
    testBasic();
    testZero();
    testNegative();
    testOffset();
    testOffsetSat();
    testGlitch();
    testOverload();
    testWide();
    finishRun();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

endmodule